// File: doc/BRIEF.md
# Temperature Sensor Poll Sequencer

This block sits above a one-wire bus master engine and keeps a single temperature sensor under continuous watch. After reset it drives every LED output high as a lamp test for a programmable number of microsecond ticks. Then it runs a fixed script in an endless loop. First it resets the bus, addresses all devices and starts a temperature conversion. It waits a long programmable interval for the conversion to complete. It then resets the bus again, addresses all devices, asks for the scratchpad and reads back its first byte.

The sequencer never touches the wire itself. For each bus step it presents an operation code and a data byte to the engine, raises a one-cycle start strobe, and waits for the engine's done pulse. When a bus reset completes, the presence level the engine sampled is copied to LED bit 0. When a byte read completes, the whole byte goes onto the LEDs. That byte is the raw low temperature byte, in which bit 0 weighs half a degree. Both delays count an external microsecond tick, so a bench can shorten them through parameters.

Top module: `tsp_poll_seq`

## Requirements
- R1: While reset is held and after it is released, `led` reads 0xFF. No `eng_start` occurs before `LAMP_US` ticks of `tick_us` have elapsed.
- R2: Each poll round begins with three engine operations in this order: a bus reset (`eng_op` = 0), a byte write (`eng_op` = 1) of 0xCC, and a byte write of 0x44.
- R3: After the done pulse of the 0x44 write, no `eng_start` occurs until at least `WAIT_US` ticks have elapsed.
- R4: After that wait, the round continues with a bus reset, a write of 0xCC, a write of 0xBE, and a byte read (`eng_op` = 2).
- R5: In the cycle after the read's done pulse, `led` equals the `eng_rdata` value presented with that pulse.
- R6: In the cycle after a bus reset's done pulse, `led[0]` equals `eng_presence` and `led[7:1]` is unchanged.
- R7: After the read's done pulse, the sequencer waits at least `WAIT_US` ticks and then starts the next round with a bus reset.
- R8: `eng_start` is high for exactly one cycle per operation and stays low until the engine has returned done.
- R9: Outside the done pulses of bus resets and reads, `led` holds its value. Done pulses of writes are ignored for the display, and so is a stray done during a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| eng_op | output | 2 | Engine operation: 0 bus reset, 1 write byte, 2 read byte |
| eng_wdata | output | 8 | Byte the engine writes |
| eng_start | output | 1 | One-cycle operation start strobe |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_presence | input | 1 | Sampled line level in the presence window, valid with done |
| eng_rdata | input | 8 | Byte read by the engine, valid with done |
| led | output | 8 | LED display register |

## Verification
The bench builds the block with `LAMP_US` = 4 and `WAIT_US` = 6 and holds `tick_us` high on every cycle. With those values the lamp test and both 800 ms waits shrink to a few cycles. Two complete poll rounds then fit comfortably inside the run, and the bench can measure the gap before each start against the parameter bound. The short waits also make it possible to inject a stray done pulse in the middle of a wait, and to apply a second reset after the loop has been running.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;
   typedef enum logic [1:0] {
      OP_BUS_RESET = 2'd0,
      OP_WRITE     = 2'd1,
      OP_READ      = 2'd2
   } bus_op_e;

   typedef struct packed {
      logic      is_wait;
      bus_op_e   op;
      logic [7:0] data;
   } step_t;

   localparam logic [7:0] CMD_ALL_DEV  = 8'hCC;
   localparam logic [7:0] CMD_CONVERT  = 8'h44;
   localparam logic [7:0] CMD_RD_SCRAT = 8'hBE;
   localparam int         SCRIPT_LEN   = 9;
endpackage

// File: rtl/tsp_script.sv
`timescale 1ns/1ps
module tsp_script
   import tsp_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);
   if (IDX_W < $clog2(SCRIPT_LEN)) begin : g_bad_idx
      $error("tsp_script: IDX_W too narrow for the script");
   end

   always_comb begin
      step = '{is_wait: 1'b0, op: OP_BUS_RESET, data: 8'h00};
      case (idx)
         IDX_W'(1): step = '{is_wait: 1'b0, op: OP_WRITE, data: CMD_ALL_DEV};
         IDX_W'(2): step = '{is_wait: 1'b0, op: OP_WRITE, data: CMD_CONVERT};
         IDX_W'(3): step = '{is_wait: 1'b1, op: OP_BUS_RESET, data: 8'h00};
         IDX_W'(5): step = '{is_wait: 1'b0, op: OP_WRITE, data: CMD_ALL_DEV};
         IDX_W'(6): step = '{is_wait: 1'b0, op: OP_WRITE, data: CMD_RD_SCRAT};
         IDX_W'(7): step = '{is_wait: 1'b0, op: OP_READ, data: 8'h00};
         IDX_W'(8): step = '{is_wait: 1'b1, op: OP_BUS_RESET, data: 8'h00};
         default:   step = '{is_wait: 1'b0, op: OP_BUS_RESET, data: 8'h00};
      endcase
   end
endmodule

// File: rtl/tsp_delay.sv
`timescale 1ns/1ps
module tsp_delay #(
   parameter int CNT_W    = 20,
   parameter int INIT_LEN = 510
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             fin
);
   if (INIT_LEN < 1 || INIT_LEN >= (1 << CNT_W)) begin : g_bad_init
      $error("tsp_delay: INIT_LEN out of range for CNT_W");
   end

   logic [CNT_W-1:0] cnt;
   logic             run;

   assign fin = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CNT_W'(INIT_LEN);
         run <= 1'b1;
      end else if (load) begin
         cnt <= len;
         run <= 1'b1;
      end else begin
         if (tick && cnt != '0) cnt <= cnt - 1'b1;
         if (fin) run <= 1'b0;
      end
   end

   a_r3_load_len: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(len)) && run);
   a_r3_no_early_fin: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !fin);
endmodule

// File: rtl/tsp_led.sv
`timescale 1ns/1ps
module tsp_led #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_all,
   input  logic [W-1:0] all_val,
   input  logic         upd_lsb,
   input  logic         lsb_val,
   output logic [W-1:0] led
);
   if (W < 2) begin : g_bad_w
      $error("tsp_led: W must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == 0) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       led[b] <= 1'b1;
            else if (upd_all) led[b] <= all_val[b];
            else if (upd_lsb) led[b] <= lsb_val;
         end
      end else begin : g_upper
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       led[b] <= 1'b1;
            else if (upd_all) led[b] <= all_val[b];
         end
      end
   end

   a_r6_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_lsb && !upd_all) |=> led[W-1:1] == $past(led[W-1:1]));
   a_r6_lsb_take: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_lsb && !upd_all) |=> led[0] == $past(lsb_val));
   a_r5_byte_take: assert property (@(posedge clk) disable iff (!rst_n)
      upd_all |=> led == $past(all_val));
endmodule

// File: rtl/tsp_poll_seq.sv
`timescale 1ns/1ps
module tsp_poll_seq
   import tsp_pkg::*;
#(
   parameter int LAMP_US = 510,
   parameter int WAIT_US = 800000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   output logic [1:0] eng_op,
   output logic [7:0] eng_wdata,
   output logic       eng_start,
   input  logic       eng_done,
   input  logic       eng_presence,
   input  logic [7:0] eng_rdata,
   output logic [7:0] led
);
   localparam int MAX_US = (LAMP_US > WAIT_US) ? LAMP_US : WAIT_US;
   localparam int CNT_W  = $clog2(MAX_US + 1);
   localparam int IDX_W  = $clog2(SCRIPT_LEN);

   if (LAMP_US < 1) begin : g_bad_lamp
      $error("tsp_poll_seq: LAMP_US must be at least 1");
   end
   if (WAIT_US < 1) begin : g_bad_wait
      $error("tsp_poll_seq: WAIT_US must be at least 1");
   end

   typedef enum logic [1:0] {S_LAMP, S_ISSUE, S_BUSY, S_WAIT} state_e;

   state_e           state;
   logic [IDX_W-1:0] idx;
   step_t            cur;
   logic             dly_fin;
   logic             dly_load;
   logic             op_done;
   logic             advance;

   tsp_script #(.IDX_W(IDX_W)) u_script (
      .idx  (idx),
      .step (cur)
   );

   tsp_delay #(.CNT_W(CNT_W), .INIT_LEN(LAMP_US)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_us),
      .load  (dly_load),
      .len   (CNT_W'(WAIT_US)),
      .fin   (dly_fin)
   );

   assign op_done   = (state == S_BUSY) && eng_done;
   assign dly_load  = (state == S_ISSUE) && cur.is_wait;
   assign eng_start = (state == S_ISSUE) && !cur.is_wait;
   assign eng_op    = cur.op;
   assign eng_wdata = cur.data;
   assign advance   = op_done || ((state == S_WAIT) && dly_fin);

   tsp_led #(.W(8)) u_led (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_all (op_done && cur.op == OP_READ),
      .all_val (eng_rdata),
      .upd_lsb (op_done && cur.op == OP_BUS_RESET),
      .lsb_val (eng_presence),
      .led     (led)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_LAMP;
         idx   <= '0;
      end else begin
         case (state)
            S_LAMP:  if (dly_fin) state <= S_ISSUE;
            S_ISSUE: state <= cur.is_wait ? S_WAIT : S_BUSY;
            S_BUSY:  if (eng_done) state <= S_ISSUE;
            S_WAIT:  if (dly_fin) state <= S_ISSUE;
            default: state <= S_LAMP;
         endcase
         if (advance)
            idx <= (idx == IDX_W'(SCRIPT_LEN - 1)) ? '0 : idx + 1'b1;
      end
   end

   a_r8_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   a_r8_quiet_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_BUSY && !eng_done) |=> !eng_start);
   a_r1_lamp_led: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_LAMP) |-> (led == 8'hFF && !eng_start));
   a_r9_led_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !op_done |=> $stable(led));
endmodule

// File: tb/sim_tsp_poll_seq.sv
`timescale 1ns/1ps
module sim_tsp_poll_seq;
   localparam int LAMP = 4;
   localparam int WAIT = 6;
   localparam int LAT  = 2;
   localparam int NVEC = 14;

   // {op[1:0], wdata[7:0], presence, rdata[7:0]}
   localparam logic [18:0] VEC [NVEC] = '{
      {2'd0, 8'h00, 1'b1, 8'h00}, {2'd1, 8'hCC, 1'b0, 8'h5A},
      {2'd1, 8'h44, 1'b0, 8'hA5}, {2'd0, 8'h00, 1'b0, 8'h00},
      {2'd1, 8'hCC, 1'b1, 8'h3C}, {2'd1, 8'hBE, 1'b1, 8'hC3},
      {2'd2, 8'h00, 1'b0, 8'h32},
      {2'd0, 8'h00, 1'b1, 8'h00}, {2'd1, 8'hCC, 1'b0, 8'h00},
      {2'd1, 8'h44, 1'b1, 8'hFF}, {2'd0, 8'h00, 1'b0, 8'h00},
      {2'd1, 8'hCC, 1'b0, 8'h77}, {2'd1, 8'hBE, 1'b1, 8'h18},
      {2'd2, 8'h00, 1'b1, 8'hC9}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_us = 1'b1;
   logic [1:0] eng_op;
   logic [7:0] eng_wdata;
   logic       eng_start;
   logic       eng_done = 1'b0;
   logic       eng_presence = 1'b0;
   logic [7:0] eng_rdata = 8'h00;
   logic [7:0] led;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] exp_led;

   always #2.5 clk = ~clk;

   tsp_poll_seq #(.LAMP_US(LAMP), .WAIT_US(WAIT)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
      .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_start(eng_start),
      .eng_done(eng_done), .eng_presence(eng_presence),
      .eng_rdata(eng_rdata), .led(led)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_start(output int n);
      n = 0;
      while (!eng_start && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic respond(input logic pres, input logic [7:0] rd);
      for (int k = 0; k < LAT; k++) begin
         @(negedge clk);
         chk(!eng_start, "R8 start while busy", eng_start, 0);
      end
      eng_done = 1'b1; eng_presence = pres; eng_rdata = rd;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   initial begin
      int gap;
      exp_led = 8'hFF;
      repeat (3) @(negedge clk);
      chk(led == 8'hFF, "R1 led in reset", led, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(led == 8'hFF && !eng_start, "R1 lamp after reset", led, 8'hFF);
      wait_start(gap);
      chk(gap + 1 >= LAMP, "R1 lamp duration", gap + 1, LAMP);
      chk(led == 8'hFF, "R1 led held through lamp", led, 8'hFF);

      for (int i = 0; i < NVEC; i++) begin
         logic [18:0] v;
         int j;
         v = VEC[i];
         j = i % 7;
         if (i > 0) wait_start(gap);
         if (j == 3) chk(gap >= WAIT, "R3 conversion wait", gap, WAIT);
         if (j == 0 && i > 0) chk(gap >= WAIT, "R7 post-read wait", gap, WAIT);
         chk(eng_start && eng_op == v[18:17] && (v[18:17] != 2'd1 || eng_wdata == v[16:9]),
             (j < 3) ? "R2 op/byte" : "R4 op/byte", {eng_op, eng_wdata}, v[18:9]);
         @(negedge clk);
         chk(!eng_start, "R8 single-cycle start", eng_start, 0);
         respond(v[8], v[7:0]);
         if (v[18:17] == 2'd0) begin
            exp_led[0] = v[8];
            chk(led == exp_led, "R6 presence to bit 0", led, exp_led);
         end else if (v[18:17] == 2'd2) begin
            exp_led = v[7:0];
            chk(led == exp_led, "R5 read byte shown", led, exp_led);
         end else begin
            chk(led == exp_led, "R9 write done ignored", led, exp_led);
         end
      end

      // stray done during the post-read wait
      @(negedge clk);
      eng_done = 1'b1; eng_presence = 1'b0; eng_rdata = 8'h11;
      @(negedge clk);
      eng_done = 1'b0;
      @(negedge clk);
      chk(led == exp_led, "R9 stray done ignored", led, exp_led);
      wait_start(gap);
      chk(gap + 3 >= WAIT, "R7 wait kept after stray done", gap + 3, WAIT);
      chk(eng_op == 2'd0, "R7 next round starts with reset", eng_op, 0);

      // reset in mid-run returns to lamp test
      rst_n = 1'b0;
      @(negedge clk);
      chk(led == 8'hFF && !eng_start, "R1 lamp on re-reset", led, 8'hFF);
      rst_n = 1'b1;
      wait_start(gap);
      chk(gap + 1 >= LAMP && eng_op == 2'd0, "R1 lamp then reset op", gap + 1, LAMP);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule